// File: doc/BRIEF.md
# Affine-Gap Local Alignment Processing Element

This block is one processing element of a linear systolic array that fills the scoring matrix of a local sequence alignment. It uses affine gap costs. Each element holds one query symbol. For every database symbol streamed past it, the element computes one matrix cell from three things:

- the diagonal, left and upper neighbour scores;
- the running horizontal-gap and vertical-gap scores;
- the alignment lengths that go with each of those values.

It returns the new cell score, the two new gap scores and three alignment lengths. A reduction stage further along the array uses those lengths to find where the best local alignment begins.

The open and extend penalties for each gap direction are configuration inputs, as are the match reward and the mismatch cost. They are expected to satisfy h_open+h_ext ≥ pen_match+pen_mismatch and v_open+v_ext ≥ pen_match+pen_mismatch. Two edge flags replace the neighbour values with the matrix border values, so the same element works in the first row and the first column. A cell takes two clock cycles, and the element accepts at most one new cell every two cycles.

Top module: `sw_cell_pe`

## Requirements
- R1: Symbols are 4-bit masks, one bit per nucleotide (bit0 A, bit1 C, bit2 G, bit3 U/T); a wildcard sets several bits. Two symbols match when the bitwise AND of their masks is non-zero. The substitution term is then +pen_match, and otherwise −pen_mismatch.
- R2: hgap_score = max(left_score − h_open, left_hgap − h_ext). On a tie or an open win, hgap_len = left_len; otherwise hgap_len = left_hlen.
- R3: vgap_score = max(up_score − v_open, up_vgap − v_ext). On a tie or an open win, vgap_len = up_len + 1; otherwise vgap_len = up_vlen + 1.
- R4: cell_score = max(0, diag_score + substitution, hgap_score, vgap_score).
- R5: cell_len is 0 when cell_score is 0. Otherwise it is diag_len + 1 if the diagonal term reaches the maximum, hgap_len if the horizontal term reaches it, and vgap_len otherwise. Ties resolve in the order zero, diagonal, horizontal, vertical.
- R6: col_edge forces the left values to score 0, horizontal gap −h_open and lengths 0. row_edge forces the upper values to score 0, vertical gap −v_open and lengths 0. Either flag forces the diagonal score and the diagonal length to 0.
- R7: Score arithmetic saturates at the signed maximum and minimum of SW bits instead of wrapping.
- R8: A cell accepted at a clock edge appears on the outputs, with out_valid high for exactly one cycle, after the second edge. The outputs hold their values until the next result.
- R9: An in_valid on the cycle that directly follows an accepted cell is ignored: it produces no result and changes no output. With in_valid held high, a cell is accepted every second cycle.
- R10: qry_in is stored at a clock edge where qry_we is high. The stored symbol is the query used for all later cells.
- R11: After reset, out_valid is 0 and all score and length outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| qry_we | input | 1 | Load the query symbol register |
| qry_in | input | SYM_W | Query symbol to store |
| in_valid | input | 1 | A new cell is presented |
| db_sym | input | SYM_W | Streamed database symbol |
| col_edge | input | 1 | Cell lies in the first column |
| row_edge | input | 1 | Cell lies in the first row |
| diag_score | input | SW | Diagonal neighbour score |
| left_score | input | SW | Left neighbour score |
| up_score | input | SW | Upper neighbour score |
| left_hgap | input | SW | Left horizontal-gap score |
| up_vgap | input | SW | Upper vertical-gap score |
| diag_len | input | LW | Diagonal neighbour length |
| left_len | input | LW | Left neighbour length |
| left_hlen | input | LW | Left horizontal-gap length |
| up_len | input | LW | Upper neighbour length |
| up_vlen | input | LW | Upper vertical-gap length |
| pen_match | input | SW | Match reward (non-negative) |
| pen_mismatch | input | SW | Mismatch cost (non-negative) |
| h_open | input | SW | Horizontal gap open cost |
| h_ext | input | SW | Horizontal gap extend cost |
| v_open | input | SW | Vertical gap open cost |
| v_ext | input | SW | Vertical gap extend cost |
| out_valid | output | 1 | One-cycle pulse: new result on the outputs |
| cell_score | output | SW | New cell score |
| hgap_score | output | SW | New horizontal-gap score |
| vgap_score | output | SW | New vertical-gap score |
| cell_len | output | LW | New cell alignment length |
| hgap_len | output | LW | New horizontal-gap length |
| vgap_len | output | LW | New vertical-gap length |

## Verification
Most wrong internal state in this element shows at the ports on the very next out_valid pulse, two edges after the cell was accepted:

- A stale or corrupted first-stage register gives a wrong gap score or a wrong length.
- A bad stage flag shows as a missing, doubled or early out_valid pulse.

A fault in the tie-breaking order changes only the lengths and leaves the scores correct. The stimulus therefore includes exact ties between the diagonal and horizontal paths and between the horizontal and vertical paths, and equal open and extend gap terms. A corrupted query register shows on every later cell as a wrong match decision. Saturation faults show only at the top of the score range, so one cell drives the diagonal sum past the signed maximum.

// File: rtl/sw_pe_pkg.sv
// Package: shared types for the alignment processing element.
// Assumes: nothing beyond standard SystemVerilog.
package sw_pe_pkg;
    // Winning path of a cell, listed in tie-break priority order.
    typedef enum logic [1:0] {
        PATH_ZERO = 2'd0,
        PATH_DIAG = 2'd1,
        PATH_HGAP = 2'd2,
        PATH_VGAP = 2'd3
    } path_e;
endpackage

// File: rtl/sw_subst.sv
// sw_subst: compares the database symbol with the query mask and adds
// the match reward or subtracts the mismatch cost from the diagonal score.
// The result saturates at the signed range of SW bits.
// Assumes: the penalties are non-negative.
module sw_subst #(
    parameter int SW    = 16,
    parameter int SYM_W = 4
) (
    input  logic [SYM_W-1:0]     db_sym,
    input  logic [SYM_W-1:0]     qry_sym,
    input  logic signed [SW-1:0] diag_score,
    input  logic signed [SW-1:0] pen_match,
    input  logic signed [SW-1:0] pen_mismatch,
    output logic signed [SW-1:0] diag_sum
);
    localparam int XW = SW + 2;
    localparam logic signed [XW-1:0] SMAX = {3'b000, {(SW-1){1'b1}}};
    localparam logic signed [XW-1:0] SMIN = {3'b111, {(SW-1){1'b0}}};

    logic                 hit;
    logic signed [XW-1:0] wide;

    // Add the substitution term in a widened domain, then clamp.
    always_comb begin
        hit  = |(db_sym & qry_sym);
        wide = hit ? (XW'(diag_score) + XW'(pen_match))
                   : (XW'(diag_score) - XW'(pen_mismatch));
        if (wide > SMAX)      diag_sum = SMAX[SW-1:0];
        else if (wide < SMIN) diag_sum = SMIN[SW-1:0];
        else                  diag_sum = wide[SW-1:0];
    end
endmodule

// File: rtl/sw_gap_path.sv
// sw_gap_path: one gap direction. Chooses between opening a gap from the
// neighbour cell and extending the neighbour's gap; opening wins ties.
// LEN_INC is added to whichever length is chosen.
// Assumes: the penalties are non-negative.
module sw_gap_path #(
    parameter int SW      = 16,
    parameter int LW      = 16,
    parameter int LEN_INC = 0
) (
    input  logic signed [SW-1:0] prev_cell,
    input  logic signed [SW-1:0] prev_gap,
    input  logic signed [SW-1:0] pen_open,
    input  logic signed [SW-1:0] pen_ext,
    input  logic [LW-1:0]        prev_cell_len,
    input  logic [LW-1:0]        prev_gap_len,
    output logic signed [SW-1:0] gap_score,
    output logic [LW-1:0]        gap_len
);
    localparam int XW = SW + 2;
    localparam logic signed [XW-1:0] SMIN = {3'b111, {(SW-1){1'b0}}};
    localparam logic [LW-1:0]        INC  = LW'(LEN_INC);

    logic signed [XW-1:0] open_w;
    logic signed [XW-1:0] ext_w;
    logic signed [XW-1:0] best_w;
    logic                 take_open;

    // Compare the open and extend candidates and keep the better one.
    always_comb begin
        open_w    = XW'(prev_cell) - XW'(pen_open);
        ext_w     = XW'(prev_gap) - XW'(pen_ext);
        take_open = (open_w >= ext_w);
        best_w    = take_open ? open_w : ext_w;
        gap_score = (best_w < SMIN) ? SMIN[SW-1:0] : best_w[SW-1:0];
        gap_len   = (take_open ? prev_cell_len : prev_gap_len) + INC;
    end
endmodule

// File: rtl/sw_cell_pe.sv
// sw_cell_pe: one affine-gap local alignment cell, in two pipeline stages.
// Stage 1 applies the edge values and registers the substitution and gap
// candidates. Stage 2 takes the maximum with a zero floor, picks the
// length by priority and registers the outputs.
// Assumes: penalties are non-negative and constant while cells are in flight.
module sw_cell_pe #(
    parameter int SW    = 16,
    parameter int LW    = 16,
    parameter int SYM_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 qry_we,
    input  logic [SYM_W-1:0]     qry_in,
    input  logic                 in_valid,
    input  logic [SYM_W-1:0]     db_sym,
    input  logic                 col_edge,
    input  logic                 row_edge,
    input  logic signed [SW-1:0] diag_score,
    input  logic signed [SW-1:0] left_score,
    input  logic signed [SW-1:0] up_score,
    input  logic signed [SW-1:0] left_hgap,
    input  logic signed [SW-1:0] up_vgap,
    input  logic [LW-1:0]        diag_len,
    input  logic [LW-1:0]        left_len,
    input  logic [LW-1:0]        left_hlen,
    input  logic [LW-1:0]        up_len,
    input  logic [LW-1:0]        up_vlen,
    input  logic signed [SW-1:0] pen_match,
    input  logic signed [SW-1:0] pen_mismatch,
    input  logic signed [SW-1:0] h_open,
    input  logic signed [SW-1:0] h_ext,
    input  logic signed [SW-1:0] v_open,
    input  logic signed [SW-1:0] v_ext,
    output logic                 out_valid,
    output logic signed [SW-1:0] cell_score,
    output logic signed [SW-1:0] hgap_score,
    output logic signed [SW-1:0] vgap_score,
    output logic [LW-1:0]        cell_len,
    output logic [LW-1:0]        hgap_len,
    output logic [LW-1:0]        vgap_len
);
    import sw_pe_pkg::*;

    logic [SYM_W-1:0]     qry_q;
    logic signed [SW-1:0] e_diag, e_left, e_up, e_lh, e_uv;
    logic [LW-1:0]        e_dlen, e_llen, e_lhlen, e_ulen, e_uvlen;
    logic signed [SW-1:0] c_diag, c_h, c_v;
    logic [LW-1:0]        c_hlen, c_vlen;
    logic                 accept;

    logic                 s1_vld;
    logic signed [SW-1:0] s1_diag, s1_h, s1_v;
    logic [LW-1:0]        s1_dlen, s1_hlen, s1_vlen;

    path_e                win;
    logic signed [SW-1:0] best;

    // Hold the query symbol of this element.
    always_ff @(posedge clk) begin
        if (!rst_n)      qry_q <= '0;
        else if (qry_we) qry_q <= qry_in;
    end

    // Replace neighbour values with border values in the first row or column.
    always_comb begin
        e_left  = col_edge ? '0 : left_score;
        e_lh    = col_edge ? -h_open : left_hgap;
        e_llen  = col_edge ? '0 : left_len;
        e_lhlen = col_edge ? '0 : left_hlen;
        e_up    = row_edge ? '0 : up_score;
        e_uv    = row_edge ? -v_open : up_vgap;
        e_ulen  = row_edge ? '0 : up_len;
        e_uvlen = row_edge ? '0 : up_vlen;
        e_diag  = (col_edge || row_edge) ? '0 : diag_score;
        e_dlen  = (col_edge || row_edge) ? '0 : diag_len;
    end

    sw_subst #(.SW(SW), .SYM_W(SYM_W)) subst_i (
        .db_sym(db_sym), .qry_sym(qry_q), .diag_score(e_diag),
        .pen_match(pen_match), .pen_mismatch(pen_mismatch), .diag_sum(c_diag)
    );

    sw_gap_path #(.SW(SW), .LW(LW), .LEN_INC(0)) hgap_i (
        .prev_cell(e_left), .prev_gap(e_lh), .pen_open(h_open), .pen_ext(h_ext),
        .prev_cell_len(e_llen), .prev_gap_len(e_lhlen),
        .gap_score(c_h), .gap_len(c_hlen)
    );

    sw_gap_path #(.SW(SW), .LW(LW), .LEN_INC(1)) vgap_i (
        .prev_cell(e_up), .prev_gap(e_uv), .pen_open(v_open), .pen_ext(v_ext),
        .prev_cell_len(e_ulen), .prev_gap_len(e_uvlen),
        .gap_score(c_v), .gap_len(c_vlen)
    );

    assign accept = in_valid && !s1_vld;

    // Stage 1: register the candidates of an accepted cell.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld  <= 1'b0;
            s1_diag <= '0;
            s1_h    <= '0;
            s1_v    <= '0;
            s1_dlen <= '0;
            s1_hlen <= '0;
            s1_vlen <= '0;
        end else begin
            s1_vld <= accept;
            if (accept) begin
                s1_diag <= c_diag;
                s1_h    <= c_h;
                s1_v    <= c_v;
                s1_dlen <= e_dlen + LW'(1);
                s1_hlen <= c_hlen;
                s1_vlen <= c_vlen;
            end
        end
    end

    // Select the winning path: zero, then diagonal, horizontal, vertical.
    always_comb begin
        best = s1_diag;
        if (s1_h > best) best = s1_h;
        if (s1_v > best) best = s1_v;
        if (best <= 0)                win = PATH_ZERO;
        else if (s1_diag == best)     win = PATH_DIAG;
        else if (s1_h == best)        win = PATH_HGAP;
        else                          win = PATH_VGAP;
    end

    // Stage 2: register the results and pulse out_valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            cell_score <= '0;
            hgap_score <= '0;
            vgap_score <= '0;
            cell_len   <= '0;
            hgap_len   <= '0;
            vgap_len   <= '0;
        end else begin
            out_valid <= s1_vld;
            if (s1_vld) begin
                hgap_score <= s1_h;
                vgap_score <= s1_v;
                hgap_len   <= s1_hlen;
                vgap_len   <= s1_vlen;
                unique case (win)
                    PATH_ZERO: begin cell_score <= '0;   cell_len <= '0;      end
                    PATH_DIAG: begin cell_score <= best; cell_len <= s1_dlen; end
                    PATH_HGAP: begin cell_score <= best; cell_len <= s1_hlen; end
                    PATH_VGAP: begin cell_score <= best; cell_len <= s1_vlen; end
                endcase
            end
        end
    end
endmodule

// File: rtl/sw_cell_pe_chk.sv
// sw_cell_pe_chk: port-level properties of the processing element.
// Assumes: bound to sw_cell_pe with matching widths.
module sw_cell_pe_chk #(
    parameter int SW = 16,
    parameter int LW = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 out_valid,
    input logic signed [SW-1:0] cell_score,
    input logic signed [SW-1:0] hgap_score,
    input logic signed [SW-1:0] vgap_score,
    input logic [LW-1:0]        cell_len
);
    // R8
    result_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R8
    result_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2));

    // R8
    hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(cell_score) && $stable(cell_len)));

    // R4
    score_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (cell_score >= 0 && cell_score >= hgap_score
                       && cell_score >= vgap_score));

    // R5
    zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cell_score == 0) |-> (cell_len == '0));
endmodule

bind sw_cell_pe sw_cell_pe_chk #(.SW(SW), .LW(LW)) chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
    .cell_score(cell_score), .hgap_score(hgap_score), .vgap_score(vgap_score),
    .cell_len(cell_len)
);

// File: tb/sw_cell_pe_tb_top.sv
`timescale 1ns/1ps
module sw_cell_pe_tb_top;
    localparam int SW = 16;
    localparam int LW = 16;
    localparam int NV = 8;
    localparam int NF = 18;
    // Fields: db qry diag left up lh uv dlen llen lhlen ulen uvlen
    //         exp_cell exp_h exp_v exp_len exp_hlen exp_vlen
    // Costs: match 3, mismatch 1, open 3, extend 1 in both directions.
    localparam int TBL [NV][NF] = '{
        '{1, 1, 5, 2, 2, 0, 0, 4, 2, 1, 2, 1,          8, -1, -1, 5, 2, 3},
        '{2, 1, 1, 0, 0, -3, -3, 1, 7, 0, 6, 0,        0, -3, -3, 0, 7, 7},
        '{2, 1, 0, 4, 0, 9, -3, 2, 3, 6, 1, 2,         8, 8, -3, 6, 6, 2},
        '{4, 1, 0, 0, 9, -3, 2, 0, 0, 0, 4, 9,         6, -3, 6, 5, 0, 5},
        '{1, 1, 2, 8, 0, 0, 0, 3, 9, 1, 2, 4,          5, 5, -1, 4, 9, 5},
        '{2, 1, 0, 7, 7, 0, 0, 0, 3, 0, 6, 0,          4, 4, 4, 3, 3, 7},
        '{1, 3, 0, 0, 0, -3, -3, 0, 1, 0, 0, 0,        3, -3, -3, 1, 1, 1},
        '{1, 1, 32766, 0, 0, -3, -3, 0, 0, 0, 0, 0,    32767, -3, -3, 1, 0, 1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic qry_we = 1'b0;
    logic [3:0] qry_in = '0;
    logic in_valid = 1'b0;
    logic [3:0] db_sym = '0;
    logic col_edge = 1'b0, row_edge = 1'b0;
    logic signed [SW-1:0] diag_score = '0, left_score = '0, up_score = '0;
    logic signed [SW-1:0] left_hgap = '0, up_vgap = '0;
    logic [LW-1:0] diag_len = '0, left_len = '0, left_hlen = '0, up_len = '0, up_vlen = '0;
    logic signed [SW-1:0] pen_match = 16'sd3, pen_mismatch = 16'sd1;
    logic signed [SW-1:0] h_open = 16'sd3, h_ext = 16'sd1, v_open = 16'sd3, v_ext = 16'sd1;
    logic out_valid;
    logic signed [SW-1:0] cell_score, hgap_score, vgap_score;
    logic [LW-1:0] cell_len, hgap_len, vgap_len;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sw_cell_pe #(.SW(SW), .LW(LW), .SYM_W(4)) dut_i (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic load_query(input int q);
        @(negedge clk);
        qry_we = 1'b1; qry_in = 4'(q);
        @(negedge clk);
        qry_we = 1'b0;
    endtask

    task automatic drive(input int db, input int dg, input int lf, input int up,
                         input int lh, input int uv, input int dl, input int ll,
                         input int lhl, input int ul, input int uvl);
        db_sym = 4'(db); diag_score = SW'(dg); left_score = SW'(lf);
        up_score = SW'(up); left_hgap = SW'(lh); up_vgap = SW'(uv);
        diag_len = LW'(dl); left_len = LW'(ll); left_hlen = LW'(lhl);
        up_len = LW'(ul); up_vlen = LW'(uvl);
    endtask

    // Present one cell at a negedge; its result is sampled two edges later.
    task automatic run_cell();
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 out_valid", int'(out_valid), 0);
        chk("R11 cell_score", int'(cell_score), 0);
        chk("R11 cell_len", int'(cell_len), 0);
        rst_n = 1'b1;

        for (int vi = 0; vi < NV; vi++) begin
            load_query(TBL[vi][1]);
            @(negedge clk);
            drive(TBL[vi][0], TBL[vi][2], TBL[vi][3], TBL[vi][4], TBL[vi][5],
                  TBL[vi][6], TBL[vi][7], TBL[vi][8], TBL[vi][9], TBL[vi][10], TBL[vi][11]);
            run_cell();
            chk("R8 out_valid", int'(out_valid), 1);
            chk(vi == 6 ? "R1 wildcard cell" : vi == 7 ? "R7 saturated cell" : "R4 cell",
                int'(cell_score), TBL[vi][12]);
            chk("R2 hgap", int'(hgap_score), TBL[vi][13]);
            chk("R3 vgap", int'(vgap_score), TBL[vi][14]);
            chk("R5 cell_len", int'(cell_len), TBL[vi][15]);
            chk("R2 hgap_len", int'(hgap_len), TBL[vi][16]);
            chk("R3 vgap_len", int'(vgap_len), TBL[vi][17]);
        end

        // R10: the stored query stays in use; U against stored A (0001) mismatches.
        load_query(1);
        @(negedge clk);
        qry_in = 4'd8;
        drive(8, 5, 0, 0, -3, -3, 0, 0, 0, 0, 0);
        run_cell();
        chk("R10 query held", int'(cell_score), 4);

        // R6: both edges force border values over garbage inputs.
        col_edge = 1'b1; row_edge = 1'b1;
        drive(1, 100, 100, 100, 100, 100, 50, 50, 50, 50, 50);
        run_cell();
        chk("R6 corner cell", int'(cell_score), 3);
        chk("R6 corner len", int'(cell_len), 1);
        chk("R6 corner vgap", int'(vgap_score), -3);
        chk("R6 corner hgap_len", int'(hgap_len), 0);

        // R6: first column only; the upper values are still used.
        row_edge = 1'b0;
        drive(2, 50, 50, 10, 50, 0, 50, 50, 50, 2, 3);
        run_cell();
        chk("R6 column cell", int'(cell_score), 7);
        chk("R6 column len", int'(cell_len), 3);
        chk("R6 column hgap", int'(hgap_score), -3);
        col_edge = 1'b0;

        // R9: a second valid directly after acceptance is ignored.
        drive(1, 5, 2, 2, 0, 0, 4, 2, 1, 2, 1);
        in_valid = 1'b1;
        @(negedge clk);
        drive(1, 20, 0, 0, -3, -3, 0, 0, 0, 0, 0);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R9 first result", int'(cell_score), 8);
        @(negedge clk);
        chk("R9 no second pulse", int'(out_valid), 0);
        @(negedge clk);
        chk("R9 no second pulse later", int'(out_valid), 0);
        chk("R9 output unchanged", int'(cell_score), 8);

        // R9: held valid gives results on alternate cycles.
        drive(1, 1, 0, 0, -3, -3, 0, 0, 0, 0, 0);
        in_valid = 1'b1;
        @(negedge clk);
        chk("R9 stream c1", int'(out_valid), 0);
        @(negedge clk);
        chk("R9 stream c2", int'(out_valid), 1);
        chk("R9 stream value", int'(cell_score), 4);
        @(negedge clk);
        chk("R9 stream c3", int'(out_valid), 0);
        @(negedge clk);
        chk("R9 stream c4", int'(out_valid), 1);
        in_valid = 1'b0;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule